// File: doc/BRIEF.md
# Mode-Aware Interrupt Status Controller

This block sits between an infrared serial link core and a host. The link core raises single-cycle event pulses (frame sent, frame received, receive area overflow, and two error conditions whose meaning depends on the link rate). The block latches each pulse into one of two register banks. The slow-rate bank is used while the link runs at the slow rate. The shared medium/fast bank is used at the two higher rates. The host sees the banks through a small 16-bit register window and gets one interrupt line.

Each bank has three registers: a read-only source register, a mask register and a write-one-to-clear register. A mode register holds a group mask bit for each bank, a group mask bit for FIFO receive, and the 2-bit transfer-mode field. A small state machine tracks that field. Its states are SLOW (code 00), MEDIUM (code 11) and FAST (code 10). Any mode-register write carrying a legal code moves the machine to the state of that code, from any state, including a write that keeps the current state. A write carrying code 01 is reserved and makes no transition. SLOW routes events to the slow bank. MEDIUM and FAST route them to the medium/fast bank. In SLOW, bit 9 means receive timeout and bit 8 means framing error. In the other two states, bit 9 means abort detected and bit 8 means CRC error.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the mode register reads 0x0111 (state SLOW, all three group masks set). Both mask registers read 0x8B80. Both source registers read 0, and irq_o is low.
- R2: Event input evt_i[0] sets bit 7 (frame transmit end), evt_i[1] sets bit 8, evt_i[2] sets bit 9, evt_i[3] sets bit 11 (transfer area overflow) and evt_i[4] sets bit 15 (frame receive end). The set bit is visible in the source register after the next clock edge.
- R3: Events go to the slow bank (source at address 1) in state SLOW and to the medium/fast bank (source at address 4) in MEDIUM or FAST. The other bank's source bits do not change.
- R4: A source bit latches on its event whether or not its mask bit or group mask is set.
- R5: Writing the clear register (address 3 for the slow bank, 6 for the medium/fast bank) clears every source bit written as 1 and leaves the source bits written as 0 unchanged. Writing back the value read from the source register clears all of those bits.
- R6: When an event and a clear write hit the same bit in the same cycle, the bit stays set.
- R7: irq_o is high exactly when the bank selected by the current state has a bit that is set in its source register and 0 in its mask register, and that bank's group mask (mode bit 0 for slow, bit 4 for medium/fast) is 0. Mask bit value 1 blocks the event.
- R8: A mode-register write (address 0) with bits 15:14 = 00, 11 or 10 moves the state to SLOW, MEDIUM or FAST. Code 01 leaves the state unchanged, while the group mask bits 0, 4 and 8 still take the written value.
- R9: Source registers ignore writes. Clear registers read 0. Mask registers keep only bits 15, 11, 9, 8 and 7. Every other bit of any register reads 0.
- R10: Changing the state never clears source bits. Pending bits of a bank drive irq_o again once that bank is selected and unmasked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 5 | Event pulses from the link core, one per event kind |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address (0 mode, 1/2/3 slow src/mask/clear, 4/5/6 medium/fast src/mask/clear) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to create is an event and a clear write on the same bit in the same clock edge. The stimulus gets there with one table row that raises the event strobe and the clear-register write in a single cycle, then reads the source register back. A second difficult case is a pending bit stranded in a bank that is no longer selected. The stimulus sets a bit in the medium/fast bank, moves the state through the reserved code and a rate change back to SLOW, and checks that irq_o follows only the selected bank until that bank's masks are opened.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int DATA_W  = 16;
    localparam int NUM_EVT = 5;

    // Bit positions decoded by software; order of evt_i follows this list.
    localparam int EVT_POS [NUM_EVT] = '{7, 8, 9, 11, 15};

    localparam int MODE_LSB   = 14;
    localparam int GM_SLOW    = 0;
    localparam int GM_FAST    = 4;
    localparam int GM_FIFO    = 8;

    typedef enum logic [1:0] {
        XM_SLOW   = 2'b00,
        XM_MEDIUM = 2'b11,
        XM_FAST   = 2'b10
    } xfer_mode_e;

    function automatic logic [DATA_W-1:0] evt_mask_f();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            m[EVT_POS[i]] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] EVT_MASK = evt_mask_f();

endpackage

// File: rtl/irq_xfer_fsm.sv
module irq_xfer_fsm
    import irq_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [1:0] code_i,
    output xfer_mode_e state_o,
    output logic       fast_sel_o
);

    xfer_mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XM_SLOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            unique case (code_i)
                2'b00:   state_d = XM_SLOW;
                2'b11:   state_d = XM_MEDIUM;
                2'b10:   state_d = XM_FAST;
                default: state_d = state_q;
            endcase
        end
    end

    always_comb begin
        state_o = state_q;
        unique case (state_q)
            XM_SLOW:   fast_sel_o = 1'b0;
            XM_MEDIUM: fast_sel_o = 1'b1;
            XM_FAST:   fast_sel_o = 1'b1;
            default:   fast_sel_o = 1'b0;
        endcase
    end

    // R8: reserved code makes no transition
    p_reserved_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && code_i == 2'b01) |=> $stable(state_q));

endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic              mask_we_i,
    input  logic              clr_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] src_o,
    output logic [DATA_W-1:0] mask_o
);

    logic [DATA_W-1:0] src_q, mask_q, set_vec, clr_vec;

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            set_vec[EVT_POS[i]] = evt_i[i];
        end
        clr_vec = clr_we_i ? (wdata_i & EVT_MASK) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            mask_q <= EVT_MASK;
        end else begin
            src_q <= (src_q & ~clr_vec) | set_vec;
            if (mask_we_i) mask_q <= wdata_i & EVT_MASK;
        end
    end

    assign src_o  = src_q;
    assign mask_o = mask_q;

    // R4 / R6: an event always leaves its bit set, even under mask or clear
    p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((src_q & $past(set_vec)) == $past(set_vec)));

    // R5: cleared bits without a racing event read 0 afterwards
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((src_q & $past(clr_vec & ~set_vec)) == '0));

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_ctl_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_o
);

    localparam int NUM_BANKS = 2;
    localparam int REGS_PER_BANK = 3;
    localparam logic [ADDR_W-1:0] A_MODE = '0;

    xfer_mode_e state;
    logic       fast_sel;
    logic       gm_slow_q, gm_fast_q, gm_fifo_q;
    logic       mode_we;
    logic [DATA_W-1:0] src_w  [NUM_BANKS];
    logic [DATA_W-1:0] mask_w [NUM_BANKS];
    logic [DATA_W-1:0] mode_rd;

    assign mode_we = wr_i && (addr_i == A_MODE);

    irq_xfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (mode_we),
        .code_i     (wdata_i[MODE_LSB+1:MODE_LSB]),
        .state_o    (state),
        .fast_sel_o (fast_sel)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gm_slow_q <= 1'b1;
            gm_fast_q <= 1'b1;
            gm_fifo_q <= 1'b1;
        end else if (mode_we) begin
            gm_slow_q <= wdata_i[GM_SLOW];
            gm_fast_q <= wdata_i[GM_FAST];
            gm_fifo_q <= wdata_i[GM_FIFO];
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(1 + REGS_PER_BANK * g);
        localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(2 + REGS_PER_BANK * g);
        localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(3 + REGS_PER_BANK * g);
        logic [NUM_EVT-1:0] bank_evt;
        assign bank_evt = (fast_sel == 1'(g)) ? evt_i : '0;

        irq_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (bank_evt),
            .mask_we_i (wr_i && addr_i == A_MASK),
            .clr_we_i  (wr_i && addr_i == A_CLR),
            .wdata_i   (wdata_i),
            .src_o     (src_w[g]),
            .mask_o    (mask_w[g])
        );
    end

    always_comb begin
        mode_rd = '0;
        mode_rd[MODE_LSB+1:MODE_LSB] = state;
        mode_rd[GM_SLOW] = gm_slow_q;
        mode_rd[GM_FAST] = gm_fast_q;
        mode_rd[GM_FIFO] = gm_fifo_q;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_MODE) rdata_o = mode_rd;
        for (int g = 0; g < NUM_BANKS; g++) begin
            if (addr_i == ADDR_W'(1 + REGS_PER_BANK * g)) rdata_o = src_w[g];
            if (addr_i == ADDR_W'(2 + REGS_PER_BANK * g)) rdata_o = mask_w[g];
        end
    end

    always_comb begin
        if (fast_sel) irq_o = !gm_fast_q && ((src_w[1] & ~mask_w[1]) != '0);
        else          irq_o = !gm_slow_q && ((src_w[0] & ~mask_w[0]) != '0);
    end

    // R3: the unselected medium/fast bank holds still unless cleared
    p_idle_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_sel && !(wr_i && addr_i == ADDR_W'(3 + REGS_PER_BANK))) |=> $stable(src_w[1]));

    // R7: an interrupt implies an open group for the selected bank
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (fast_sel ? !gm_fast_q : !gm_slow_q));

    // R9: source bits exist only at event positions
    p_src_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_w[0] | src_w[1]) & ~EVT_MASK) == '0);

endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  evt_i = '0;
    logic        wr_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_status_ctrl uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    // Row: op(2) addr(3) data(16) evt(5) exp(16) irq(1) req(4)
    // op 0 write, 1 event, 2 read-check, 3 write and event in one cycle
    localparam int N = 37;
    localparam logic [46:0] TBL [N] = '{
        {2'd1, 3'd0, 16'h0000, 5'b00001, 16'h0000, 1'b0, 4'd2},
        {2'd2, 3'd1, 16'h0000, 5'b00000, 16'h0080, 1'b0, 4'd2},  // R2 bit7, R4 masked
        {2'd1, 3'd0, 16'h0000, 5'b00010, 16'h0000, 1'b0, 4'd2},
        {2'd2, 3'd1, 16'h0000, 5'b00000, 16'h0180, 1'b0, 4'd2},  // R2 bit8
        {2'd1, 3'd0, 16'h0000, 5'b11100, 16'h0000, 1'b0, 4'd2},
        {2'd2, 3'd1, 16'h0000, 5'b00000, 16'h8B80, 1'b0, 4'd4},  // R2 bits 9/11/15, R4
        {2'd2, 3'd4, 16'h0000, 5'b00000, 16'h0000, 1'b0, 4'd3},  // R3 other bank untouched
        {2'd0, 3'd2, 16'hFF7F, 5'b00000, 16'h0000, 1'b0, 4'd9},
        {2'd2, 3'd2, 16'h0000, 5'b00000, 16'h8B00, 1'b0, 4'd9},  // R9 mask bits only, R7 group closed
        {2'd0, 3'd0, 16'h0110, 5'b00000, 16'h0000, 1'b0, 4'd7},
        {2'd2, 3'd0, 16'h0000, 5'b00000, 16'h0110, 1'b1, 4'd7},  // R7 irq opens
        {2'd0, 3'd3, 16'h0080, 5'b00000, 16'h0000, 1'b0, 4'd5},
        {2'd2, 3'd1, 16'h0000, 5'b00000, 16'h8B00, 1'b0, 4'd5},  // R5 only bit7 cleared
        {2'd0, 3'd1, 16'h0000, 5'b00000, 16'h0000, 1'b0, 4'd9},
        {2'd2, 3'd1, 16'h0000, 5'b00000, 16'h8B00, 1'b0, 4'd9},  // R9 source ignores write
        {2'd2, 3'd3, 16'h0000, 5'b00000, 16'h0000, 1'b0, 4'd9},  // R9 clear reads 0
        {2'd0, 3'd0, 16'hC100, 5'b00000, 16'h0000, 1'b0, 4'd8},
        {2'd2, 3'd0, 16'h0000, 5'b00000, 16'hC100, 1'b0, 4'd8},  // R8 to MEDIUM
        {2'd1, 3'd0, 16'h0000, 5'b00001, 16'h0000, 1'b0, 4'd3},
        {2'd2, 3'd4, 16'h0000, 5'b00000, 16'h0080, 1'b0, 4'd3},  // R3 routed to fast bank
        {2'd2, 3'd1, 16'h0000, 5'b00000, 16'h8B00, 1'b0, 4'd3},  // R3 slow bank unchanged
        {2'd0, 3'd5, 16'h0000, 5'b00000, 16'h0000, 1'b0, 4'd7},
        {2'd2, 3'd5, 16'h0000, 5'b00000, 16'h0000, 1'b1, 4'd7},  // R7 fast bank irq
        {2'd0, 3'd0, 16'h4110, 5'b00000, 16'h0000, 1'b0, 4'd8},
        {2'd2, 3'd0, 16'h0000, 5'b00000, 16'hC110, 1'b0, 4'd8},  // R8 reserved code holds state
        {2'd0, 3'd0, 16'h8100, 5'b00000, 16'h0000, 1'b0, 4'd8},
        {2'd2, 3'd0, 16'h0000, 5'b00000, 16'h8100, 1'b1, 4'd8},  // R8 to FAST
        {2'd0, 3'd0, 16'h0100, 5'b00000, 16'h0000, 1'b0, 4'd10},
        {2'd2, 3'd0, 16'h0000, 5'b00000, 16'h0100, 1'b0, 4'd10}, // R10 back to SLOW, masked
        {2'd0, 3'd2, 16'h0000, 5'b00000, 16'h0000, 1'b0, 4'd10},
        {2'd2, 3'd2, 16'h0000, 5'b00000, 16'h0000, 1'b1, 4'd10}, // R10 pending bits re-exposed
        {2'd3, 3'd3, 16'h8000, 5'b10000, 16'h0000, 1'b0, 4'd6},
        {2'd2, 3'd1, 16'h0000, 5'b00000, 16'h8B00, 1'b1, 4'd6},  // R6 race keeps bit
        {2'd0, 3'd3, 16'h8B00, 5'b00000, 16'h0000, 1'b0, 4'd5},
        {2'd2, 3'd1, 16'h0000, 5'b00000, 16'h0000, 1'b0, 4'd5},  // R5 write-back clears
        {2'd0, 3'd6, 16'h0080, 5'b00000, 16'h0000, 1'b0, 4'd5},
        {2'd2, 3'd4, 16'h0000, 5'b00000, 16'h0000, 1'b0, 4'd5}   // R5 fast bank clear
    };

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic read_chk(input logic [2:0] a, input logic [15:0] exp, input logic exp_irq, input int req);
        @(negedge clk);
        addr_i = a;
        #1;
        check(req, rdata_o, exp, $sformatf("rdata addr %0d", a));
        check(req, {15'd0, irq_o}, {15'd0, exp_irq}, "irq");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        read_chk(3'd0, 16'h0111, 1'b0, 1);
        read_chk(3'd2, 16'h8B80, 1'b0, 1);
        read_chk(3'd5, 16'h8B80, 1'b0, 1);
        read_chk(3'd1, 16'h0000, 1'b0, 1);
        read_chk(3'd4, 16'h0000, 1'b0, 1);
        for (int i = 0; i < N; i++) begin
            logic [1:0]  op;
            op = TBL[i][46:45];
            if (op == 2'd2) begin
                read_chk(TBL[i][44:42], TBL[i][20:5], TBL[i][4], int'(TBL[i][3:0]));
            end else begin
                @(negedge clk);
                addr_i  = TBL[i][44:42];
                wdata_i = TBL[i][41:26];
                wr_i    = (op != 2'd1);
                evt_i   = (op != 2'd0) ? TBL[i][25:21] : 5'b0;
                @(negedge clk);
                wr_i  = 1'b0;
                evt_i = '0;
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule